// File: doc/BRIEF.md
# Beam Position Counter with Capture Strobe

This block tracks the position of a raster beam in master-clock cycles. It keeps a horizontal dot counter, a vertical line counter and a frame parity flag. A dot normally lasts four master cycles. Two dots on each scanline are stretched to six cycles, so a normal scanline is 1364 cycles long. One line in every other non-interlaced frame drops the stretch, so every dot on that line is four cycles and the line is 1360 cycles long.

A one-cycle capture strobe is asserted on the exact bus cycle in which the position register is read. On that cycle the current dot and line are copied into holding registers, and software reads them there. Because the copy happens on the read cycle, the captured value does not depend on where the reading instruction ends.

An interlace input selects the frame structure. Interlace must only change while reset is held.

Top module: `beam_pos_latch`

## Requirements
- R1: While rst_ni is low and on the first sampling after release, dot_o, line_o, the held capture outputs and field_odd_o are all zero. field_odd_o at 0 means an even frame.
- R2: Every dot other than the two stretched ones lasts SHORT_CYC (4) master cycles. dot_o steps by one when a dot ends.
- R3: Dots LONG_A (323) and LONG_B (327) last LONG_CYC (6) master cycles, which makes a normal line 1364 cycles long.
- R4: With interlace_i low and field_odd_o at 1, line SHORT_LINE (240) has no stretched dots. It lasts DOTS*SHORT_CYC (1360) cycles, and its highest dot is DOTS-1 (339).
- R5: With interlace_i high, line SHORT_LINE keeps both stretched dots in every frame.
- R6: A non-interlaced frame has LINES (262) lines. An interlaced frame with field_odd_o at 0 has LINES+1 lines, and one with field_odd_o at 1 has LINES lines.
- R7: field_odd_o toggles exactly when the position wraps to line 0, dot 0 at the end of a frame, and at no other time.
- R8: When cap_i is high at a rising clock edge, cap_dot_o and cap_line_o show the dot and line that were present just before that edge, starting with the following cycle.
- R9: While cap_i is low, cap_dot_o and cap_line_o keep their values.
- R10: After dot DOTS-1 has ended, dot_o returns to 0 and line_o advances by one, or returns to 0 on the last line of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interlace_i | input | 1 | Interlace frame structure select |
| cap_i | input | 1 | Capture strobe, high on the register read cycle |
| dot_o | output | 9 | Current horizontal dot |
| line_o | output | 9 | Current scanline |
| field_odd_o | output | 1 | Frame parity, 1 means odd |
| cap_dot_o | output | 9 | Dot held by the last capture |
| cap_line_o | output | 9 | Line held by the last capture |

## Verification
A sub-dot counter that wraps at the wrong count shifts dot_o against the cycle count within one dot. Because the drift only accumulates, every later comparison of dot_o fails as well. A wrong short-line or frame-length decision first shows up on the line after the affected one, or on the first cycle of the next frame, as a line_o or field_odd_o mismatch. A faulty capture path shows up on the cycle right after a strobe, or as drift in the held values while the strobe is idle.

// File: rtl/beam_pkg.sv
package beam_pkg;
  localparam int unsigned POS_W = 9;
  typedef logic [POS_W-1:0] pos_t;
endpackage

// File: rtl/beam_sub_cnt.sv
module beam_sub_cnt #(
  parameter int unsigned SHORT_CYC = 4,
  parameter int unsigned LONG_CYC  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_i,
  output logic step_o
);
  localparam int unsigned SW = $clog2(LONG_CYC);
  localparam logic [SW-1:0] SHORT_END = SW'(SHORT_CYC - 1);
  localparam logic [SW-1:0] LONG_END  = SW'(LONG_CYC - 1);

  logic [SW-1:0] sub_q;

  assign step_o = (sub_q == (long_i ? LONG_END : SHORT_END));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sub_q <= '0;
    else if (step_o) sub_q <= '0;
    else             sub_q <= sub_q + 1'b1;
  end
endmodule

// File: rtl/beam_pos_ctr.sv
module beam_pos_ctr
  import beam_pkg::*;
#(
  parameter int unsigned DOTS       = 340,
  parameter int unsigned LINES      = 262,
  parameter int unsigned LONG_A     = 323,
  parameter int unsigned LONG_B     = 327,
  parameter int unsigned SHORT_LINE = 240
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic interlace_i,
  input  logic step_i,
  output logic long_o,
  output pos_t dot_o,
  output pos_t line_o,
  output logic field_odd_o
);
  localparam pos_t DOT_MAX  = POS_W'(DOTS - 1);
  localparam pos_t LINE_NI  = POS_W'(LINES - 1);
  localparam pos_t LINE_IL  = POS_W'(LINES);
  localparam pos_t DOT_LA   = POS_W'(LONG_A);
  localparam pos_t DOT_LB   = POS_W'(LONG_B);
  localparam pos_t LINE_SH  = POS_W'(SHORT_LINE);

  pos_t dot_q, line_q;
  logic field_q;
  logic short_line, last_line, dot_end;

  // shortened line only in non-interlace odd frames
  assign short_line = !interlace_i && field_q && (line_q == LINE_SH);
  assign long_o     = !short_line && ((dot_q == DOT_LA) || (dot_q == DOT_LB));
  assign last_line  = (line_q == ((interlace_i && !field_q) ? LINE_IL : LINE_NI));
  assign dot_end    = (dot_q == DOT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q   <= '0;
      line_q  <= '0;
      field_q <= 1'b0;
    end else if (step_i) begin
      if (dot_end) begin
        dot_q <= '0;
        if (last_line) begin
          line_q  <= '0;
          field_q <= ~field_q;
        end else begin
          line_q <= line_q + 1'b1;
        end
      end else begin
        dot_q <= dot_q + 1'b1;
      end
    end
  end

  assign dot_o       = dot_q;
  assign line_o      = line_q;
  assign field_odd_o = field_q;

  a_r2_dot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_q != $past(dot_q)) |-> ((dot_q == $past(dot_q) + 1'b1) || (dot_q == '0)));
  a_r10_dot_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && dot_end) |=> ((dot_q == '0) && (line_q != $past(line_q))));
  a_r7_field_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_q != $past(field_q)) |-> ((line_q == '0) && (dot_q == '0)));
endmodule

// File: rtl/beam_latch.sv
module beam_latch
  import beam_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  pos_t dot_i,
  input  pos_t line_i,
  output pos_t cap_dot_o,
  output pos_t cap_line_o
);
  pos_t dot_q, line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q  <= '0;
      line_q <= '0;
    end else if (cap_i) begin
      dot_q  <= dot_i;
      line_q <= line_i;
    end
  end

  assign cap_dot_o  = dot_q;
  assign cap_line_o = line_q;

  a_r8_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> ((dot_q == $past(dot_i)) && (line_q == $past(line_i))));
  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> ($stable(dot_q) && $stable(line_q)));
endmodule

// File: rtl/beam_pos_latch.sv
module beam_pos_latch
  import beam_pkg::*;
#(
  parameter int unsigned SHORT_CYC  = 4,
  parameter int unsigned LONG_CYC   = 6,
  parameter int unsigned DOTS       = 340,
  parameter int unsigned LINES      = 262,
  parameter int unsigned LONG_A     = 323,
  parameter int unsigned LONG_B     = 327,
  parameter int unsigned SHORT_LINE = 240
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       interlace_i,
  input  logic       cap_i,
  output logic [8:0] dot_o,
  output logic [8:0] line_o,
  output logic       field_odd_o,
  output logic [8:0] cap_dot_o,
  output logic [8:0] cap_line_o
);
  logic step, long_dot;
  pos_t dot, line;

  beam_sub_cnt #(
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC)
  ) u_sub (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .long_i(long_dot),
    .step_o(step)
  );

  beam_pos_ctr #(
    .DOTS      (DOTS),
    .LINES     (LINES),
    .LONG_A    (LONG_A),
    .LONG_B    (LONG_B),
    .SHORT_LINE(SHORT_LINE)
  ) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .interlace_i(interlace_i),
    .step_i     (step),
    .long_o     (long_dot),
    .dot_o      (dot),
    .line_o     (line),
    .field_odd_o(field_odd_o)
  );

  beam_latch u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap_i),
    .dot_i     (dot),
    .line_i    (line),
    .cap_dot_o (cap_dot_o),
    .cap_line_o(cap_line_o)
  );

  assign dot_o  = dot;
  assign line_o = line;
endmodule

// File: tb/beam_pos_latch_bench.sv
module beam_pos_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SC = 4, LC = 6, DOTS = 12, LINES = 8, LA = 5, LB = 9, SL = 5;

  logic clk = 1'b0, rst_ni = 1'b0, il = 1'b0, cap = 1'b0;
  logic [8:0] dot_o, line_o, cdot, cline;
  logic field_o;
  int errors = 0, checks = 0;
  int off, par, hd, hl, ed, el, ncyc;
  bit done = 0, last_cap;

  always #(CLK_PERIOD/2) clk = ~clk;

  beam_pos_latch #(.SHORT_CYC(SC), .LONG_CYC(LC), .DOTS(DOTS), .LINES(LINES),
    .LONG_A(LA), .LONG_B(LB), .SHORT_LINE(SL)) u_beam_pos_latch (
    .clk_i(clk), .rst_ni(rst_ni), .interlace_i(il), .cap_i(cap),
    .dot_o(dot_o), .line_o(line_o), .field_odd_o(field_o),
    .cap_dot_o(cdot), .cap_line_o(cline));

  function automatic bit is_short(int ln, int p);
    return !il && p == 1 && ln == SL;
  endfunction
  function automatic int line_len(int ln, int p);
    return is_short(ln, p) ? DOTS*SC : (DOTS-2)*SC + 2*LC;
  endfunction
  function automatic int n_lines(int p);
    return (il && p == 0) ? LINES+1 : LINES;
  endfunction
  function automatic int frame_len(int p);
    int s = 0;
    for (int i = 0; i < n_lines(p); i++) s += line_len(i, p);
    return s;
  endfunction

  task automatic decode(input int o, input int p);
    int r = o, d;
    el = 0;
    while (r >= line_len(el, p)) begin r -= line_len(el, p); el++; end
    if (is_short(el, p) || r < LA*SC) d = r / SC;
    else begin
      r -= LA*SC;
      if (r < LC) d = LA;
      else begin
        r -= LC;
        if (r < (LB-LA-1)*SC) d = LA + 1 + r / SC;
        else begin
          r -= (LB-LA-1)*SC;
          d = (r < LC) ? LB : LB + 1 + (r - LC) / SC;
        end
      end
    end
    ed = d;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_mode(input bit mode, input int cycles);
    string t;
    rst_ni = 1'b0; il = mode; cap = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 dot", dot_o, 0); chk("R1 line", line_o, 0);
    chk("R1 field", field_o, 0); chk("R1 cap", cdot + cline, 0);
    rst_ni = 1'b1;
    off = 0; par = 0; hd = 0; hl = 0; last_cap = 0;
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk);
      off++;
      if (off == frame_len(par)) begin off = 0; par ^= 1; end
      @(negedge clk);
      decode(off, par);
      if (is_short(el, par)) t = "R4";
      else if (il && el == SL && (ed == LA || ed == LB)) t = "R5";
      else if (ed == LA || ed == LB) t = "R3";
      else if (ed == 0) t = "R10";
      else t = "R2";
      chk(t, dot_o, ed);
      chk(off == 0 ? "R6 line" : "R10 line", line_o, el);
      chk("R7", field_o, par);
      chk(last_cap ? "R8 dot" : "R9 dot", cdot, hd);
      chk(last_cap ? "R8 line" : "R9 line", cline, hl);
      last_cap = (k % 37 == 11) || (k % 53 == 0);
      cap = last_cap;
      if (last_cap) begin hd = ed; hl = el; end
    end
    cap = 1'b0;
  endtask

  initial begin
    ncyc = 0;
    run_mode(1'b0, 6*frame_len(0) + 20);
    run_mode(1'b1, 6*frame_len(0) + 20);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule